// File: doc/BRIEF.md
# Audio Clock Divider Chain

This block derives the three clocks of a stereo serial audio link from a single module clock. A coded master-clock divider runs first. The bit clock is divided down from the master clock, and the frame (left/right) clock is divided down from the bit clock, so that each frame holds two words of `WORD_BITS` bits. Both dividers take small codes rather than binary divide values. The codes select ratios from fixed tables, and some of those ratios are not powers of two.

Everything runs in the module-clock domain. Each stage is a counter that advances on a one-cycle tick from the stage before it. Divider settings come in on an 8-bit configuration byte. A new setting is held back until the next rising edge of the frame clock, so the clocks never change ratio in the middle of a frame. Bit 7 of the byte gates the master clock output pin only. The divider chain keeps running while that pin is held low.

Top module: `aud_clkdiv`

## Requirements
- R1: While reset is asserted, all three clock outputs are low. Reset leaves both divider codes at 0 and the master output disabled.
- R2: The master divider code is `cfg[3:0]`. Codes 0..7 divide the module clock by 1, 2, 4, 6, 8, 12, 16, 24. Codes 8..15 divide by 24.
- R3: The bit divider code is `cfg[6:4]`. Codes 0..5 divide the master clock by 2, 4, 6, 8, 12, 16. Codes 6 and 7 divide by 16.
- R4: Every divided output with an even ratio has a 50% duty cycle. It is high for half of its period, measured in module-clock cycles.
- R5: The frame clock has a period of 2*WORD_BITS bit-clock periods and is high for the first WORD_BITS of them. Its rising edge coincides with a bit-clock rising edge.
- R6: A change to either divider code has no effect until the next rising edge of the frame clock. Until then the old ratios stay in force.
- R7: `cfg[7]` enables the master clock pin. When it is 0 the pin is low, while the bit and frame clocks continue.
- R8: With master ratio 1, the master clock pin carries the module clock itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mod | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg | input | 8 | [7] master pin enable, [6:4] bit divider code, [3:0] master divider code |
| mclk_o | output | 1 | Master clock |
| bclk_o | output | 1 | Bit clock |
| fclk_o | output | 1 | Frame clock |

## Verification
On every cycle, the embedded assertions check the following. Each stage counter stays inside its ratio. A divided output moves only on a tick from the stage before it. The active ratios stay frozen between frame-clock rising edges. Every frame rising edge lands on a bit-clock rising edge. Only the bench scenarios can show the actual periods and duty cycles behind each code, including the fallback codes. The bench also measures the one-frame delay before a new code takes hold, the pass-through at ratio 1, and a silent master pin while the other clocks keep running.

// File: rtl/aud_clkdiv_pkg.sv
package aud_clkdiv_pkg;
   localparam int RATIO_W = 5;

   function automatic logic [RATIO_W-1:0] mclk_ratio(input logic [3:0] code);
      case (code)
         4'd0:    mclk_ratio = 5'd1;
         4'd1:    mclk_ratio = 5'd2;
         4'd2:    mclk_ratio = 5'd4;
         4'd3:    mclk_ratio = 5'd6;
         4'd4:    mclk_ratio = 5'd8;
         4'd5:    mclk_ratio = 5'd12;
         4'd6:    mclk_ratio = 5'd16;
         default: mclk_ratio = 5'd24;
      endcase
   endfunction

   function automatic logic [RATIO_W-1:0] bclk_ratio(input logic [2:0] code);
      case (code)
         3'd0:    bclk_ratio = 5'd2;
         3'd1:    bclk_ratio = 5'd4;
         3'd2:    bclk_ratio = 5'd6;
         3'd3:    bclk_ratio = 5'd8;
         3'd4:    bclk_ratio = 5'd12;
         default: bclk_ratio = 5'd16;
      endcase
   endfunction
endpackage

// File: rtl/aud_clkdiv_stage.sv
module aud_clkdiv_stage #(
   parameter int CW      = 5,
   parameter int RST_CNT = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic [CW-1:0] ratio,
   input  logic          restart,
   input  logic [CW-1:0] ratio_nx,
   output logic          lvl,
   output logic          tick
);
   logic [CW-1:0] cnt;
   logic [CW-1:0] cnt_inc;
   logic          term;

   initial begin
      if (CW < 2) $error("stage counter width too small");
      if (RST_CNT >= (1 << CW)) $error("reset count does not fit");
   end

   assign term    = (cnt == ratio - 1'b1);
   assign tick    = adv & term;
   assign cnt_inc = term ? '0 : cnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= CW'(RST_CNT);
         lvl <= 1'b0;
      end else if (restart) begin
         cnt <= '0;
         lvl <= (ratio_nx >> 1) != '0;
      end else if (adv) begin
         cnt <= cnt_inc;
         lvl <= cnt_inc < (ratio >> 1);
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < ratio);                                            // R4
   AST_LVL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(lvl));                                  // R5
endmodule

// File: rtl/aud_clkdiv.sv
module aud_clkdiv
   import aud_clkdiv_pkg::*;
#(
   parameter int WORD_BITS = 16
) (
   input  logic       clk_mod,
   input  logic       rst_n,
   input  logic [7:0] cfg,
   output logic       mclk_o,
   output logic       bclk_o,
   output logic       fclk_o
);
   localparam int FRAME_LEN = 2 * WORD_BITS;
   localparam int FCW       = $clog2(FRAME_LEN) + 1;

   generate
      if (WORD_BITS < 2) begin : g_bad_word
         initial $error("WORD_BITS must be at least 2");
      end
   endgenerate

   logic [RATIO_W-1:0] mr_act, br_act, mr_nx, br_nx;
   logic               mclk_lvl, mtick;
   logic               bclk_lvl, btick;
   logic               fclk_lvl, ftick;
   logic [FCW-1:0]     frame_len;

   assign mr_nx     = mclk_ratio(cfg[3:0]);
   assign br_nx     = bclk_ratio(cfg[6:4]);
   assign frame_len = FCW'(FRAME_LEN);

   always_ff @(posedge clk_mod or negedge rst_n) begin
      if (!rst_n) begin
         mr_act <= mclk_ratio(4'd0);
         br_act <= bclk_ratio(3'd0);
      end else if (ftick) begin
         mr_act <= mr_nx;
         br_act <= br_nx;
      end
   end

   aud_clkdiv_stage #(.CW(RATIO_W), .RST_CNT(0)) u_mstage (
      .clk(clk_mod), .rst_n(rst_n), .adv(1'b1), .ratio(mr_act),
      .restart(ftick), .ratio_nx(mr_nx), .lvl(mclk_lvl), .tick(mtick));

   aud_clkdiv_stage #(.CW(RATIO_W), .RST_CNT(1)) u_bstage (
      .clk(clk_mod), .rst_n(rst_n), .adv(mtick), .ratio(br_act),
      .restart(ftick), .ratio_nx(br_nx), .lvl(bclk_lvl), .tick(btick));

   aud_clkdiv_stage #(.CW(FCW), .RST_CNT(FRAME_LEN - 1)) u_fstage (
      .clk(clk_mod), .rst_n(rst_n), .adv(btick), .ratio(frame_len),
      .restart(ftick), .ratio_nx(frame_len), .lvl(fclk_lvl), .tick(ftick));

   always_comb begin
      if (!cfg[7] || !rst_n) mclk_o = 1'b0;
      else if (mr_act == 5'd1) mclk_o = clk_mod;
      else mclk_o = mclk_lvl;
   end
   assign bclk_o = bclk_lvl;
   assign fclk_o = fclk_lvl;

   AST_CFG_FRAME_SYNC: assert property (@(posedge clk_mod) disable iff (!rst_n)
      !ftick |=> ($stable(mr_act) && $stable(br_act)));          // R6
   AST_FRAME_ON_BCLK: assert property (@(posedge clk_mod) disable iff (!rst_n)
      $rose(fclk_o) |-> $rose(bclk_o));                          // R5
   AST_BCLK_ON_MTICK: assert property (@(posedge clk_mod) disable iff (!rst_n)
      !mtick |=> $stable(bclk_o));                               // R3
endmodule

// File: tb/aud_clkdiv_bench.sv
module aud_clkdiv_bench;
   localparam int W = 8;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0] cfg = 8'h00;
   logic mclk_o, bclk_o, fclk_o;
   int total = 0, bad = 0, cyc = 0;
   bit done = 0;

   always #2 clk = ~clk;

   aud_clkdiv #(.WORD_BITS(W)) u_aud_clkdiv (
      .clk_mod(clk), .rst_n(rst_n), .cfg(cfg),
      .mclk_o(mclk_o), .bclk_o(bclk_o), .fclk_o(fclk_o));

   function automatic int exp_m(input int code);
      int t[8] = '{1, 2, 4, 6, 8, 12, 16, 24};
      return (code > 7) ? 24 : t[code];
   endfunction
   function automatic int exp_b(input int code);
      int t[6] = '{2, 4, 6, 8, 12, 16};
      return (code > 5) ? 16 : t[code];
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic sig(input int which);
      case (which)
         0: return mclk_o;
         1: return bclk_o;
         default: return fclk_o;
      endcase
   endfunction

   task automatic wait_rise(input int which);
      logic p, c;
      p = sig(which);
      forever begin
         @(negedge clk);
         c = sig(which);
         if (!p && c) break;
         p = c;
      end
   endtask

   task automatic measure(input int which, output int hi, output int per);
      wait_rise(which);
      hi = 0;
      do begin @(negedge clk); hi++; end while (sig(which) == 1'b1);
      per = hi;
      do begin @(negedge clk); per++; end while (sig(which) == 1'b0);
   endtask

   int cur_m = 1, cur_b = 2;

   task automatic run_case(input int mc, input int bc, input bit en);
      int hi, per, nm, nb, mhigh;
      nm = exp_m(mc);
      nb = exp_b(bc);
      wait_rise(2);
      cfg = {en, 3'(bc), 4'(mc)};
      measure(1, hi, per);
      chk("R6 old bclk period", per, cur_m * cur_b);
      wait_rise(2);
      cur_m = nm; cur_b = nb;
      measure(1, hi, per);
      chk("R3 bclk period", per, nm * nb);
      chk("R4 bclk high", hi, nm * nb / 2);
      if (en && nm > 1) begin
         measure(0, hi, per);
         chk("R2 mclk period", per, nm);
         chk("R4 mclk high", hi, nm / 2);
      end else if (!en) begin
         mhigh = 0;
         for (int i = 0; i < 3 * nm * nb; i++) begin
            @(negedge clk);
            if (mclk_o) mhigh++;
         end
         chk("R7 mclk held low", mhigh, 0);
      end
      measure(2, hi, per);
      chk("R5 fclk period", per, 2 * W * nm * nb);
      chk("R5 fclk high", hi, W * nm * nb);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000 && !done) begin
         done = 1;
         bad++; total++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int mc, bc, pos;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      chk("R1 mclk in reset", mclk_o, 0);
      chk("R1 bclk in reset", bclk_o, 0);
      chk("R1 fclk in reset", fclk_o, 0);
      rst_n = 1'b1;
      // R1: reset codes give master ratio 1, bit ratio 2
      run_case(0, 0, 1'b0);
      // R8: ratio 1 with the pin enabled passes the module clock
      cfg = 8'h80;
      wait_rise(2); wait_rise(2);
      pos = 0;
      for (int i = 0; i < 8; i++) begin
         @(posedge clk); #1;
         if (mclk_o) pos++;
         @(negedge clk); #1;
         if (mclk_o) pos++;
      end
      chk("R8 passthrough high phases", pos, 8);
      // directed: non-power-of-two ratios and fallback codes
      run_case(3, 2, 1'b1);
      run_case(7, 0, 1'b1);
      run_case(15, 0, 1'b1);
      run_case(1, 7, 1'b1);
      run_case(2, 6, 1'b0);
      run_case(5, 4, 1'b1);
      for (int n = 0; n < 8; n++) begin
         do begin
            mc = $urandom_range(15, 0);
            bc = $urandom_range(7, 0);
         end while (exp_m(mc) * exp_b(bc) > 96);
         run_case(mc, bc, 1'($urandom_range(1, 0)));
      end
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule